// File: doc/BRIEF.md
# MMU Control and Fault Register Block

This block is the software-facing register slave of an IO address-translation unit. It stores the operating mode, a configuration word and the page-table base, and it produces one-cycle invalidation pulses for the translation caches. A block handshake lets software stop the translation path safely. A block request takes effect only once the datapath reports that it is idle, and software polls a status bit to learn that the unit has stopped.

The translation datapath is outside this block. It reports a quiet pipeline on `dp_idle` and reports faults on four one-cycle event lines, each with its own faulting address. A fault blocks the unit at once and latches the address into the register for that fault type. It also sets an interrupt status bit, which raises `irq`. The unit stays blocked until software has cleared every pending status bit (write-one-to-clear) and has put the control register back into its enabled code.

Top module: `mmu_regblock`

## Requirements
- R1: After reset, control, config, status, interrupt status, page-table base and all fault address registers read 0, and `xlat_en`, `blocked` and `irq` are low. The version register at 0x034 reads the 11-bit version in bits [31:21], with the major number in [31:28] and the minor number in [27:21]; all other bits read 0.
- R2: At control offset 0x000, writing 0x5 selects enabled mode and writing 0x0 selects disabled mode. Control reads back the code of the current mode (0x0, 0x5 or 0x7). A write of any other value leaves the mode unchanged. `xlat_en` is high only in enabled mode while the unit is not blocked.
- R3: Writing 0x7 to control requests blocking, and `xlat_en` drops after that write. Status bit 0 (offset 0x008) and `blocked` stay 0 while `dp_idle` is low. They become 1 at the first clock edge at which `dp_idle` is high, and they remain 1 while the request stands.
- R4: A fault event for type i sets interrupt status bit i (offset 0x018) at the next edge, and also raises `irq`, sets `blocked` without waiting for idle, captures the event's address into that type's register, and changes control to read 0x7. The type order is: bit 0 page fault (0x024), bit 1 write-channel fault (0x028), bit 2 read-channel fault (0x02C), bit 3 default-slave fault (0x030).
- R5: Writing a mask to interrupt clear (0x01C) clears exactly the status bits written as 1. A fault event in the same cycle as the clear of its bit leaves the bit set.
- R6: A fault address register captures only while its status bit is clear. A repeated fault of a pending type keeps the first address.
- R7: Fault events of several types in one cycle each set their own status bit and capture their own address.
- R8: While any interrupt status bit is set, the unit stays blocked, even after control has been written 0x5. After the last bit is cleared with control at 0x5, `blocked` falls one cycle later and `xlat_en` rises.
- R9: A write to flush-all (0x00C) with bit 0 set gives a one-cycle `flush_all` pulse in the following cycle. A write to flush-entry (0x010) with bit 0 set gives a one-cycle `flush_one` pulse, and `flush_va` carries bits [31:12] of the written word. A write with bit 0 clear gives no pulse. Both offsets read 0.
- R10: The page-table base (0x014) is read/write and drives `pt_base`. Config (0x004) stores only the bits set in parameter CFG_WMASK (default 0x00FF_FFFF) and drives `cfg`.
- R11: Unimplemented or unaligned offsets read 0. Writes to the interrupt status offset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| dp_idle | input | 1 | Datapath has no translation in flight |
| fault_evt | input | 4 | One-cycle fault events, one per fault type |
| fault_va | input | 128 | Faulting address per type, type i in bits [32i+31:32i] |
| xlat_en | output | 1 | Translation may proceed |
| blocked | output | 1 | Unit is in the blocked state (mirrors status bit 0) |
| irq | output | 1 | OR of the interrupt status bits |
| flush_all | output | 1 | One-cycle pulse to invalidate all cached translations |
| flush_one | output | 1 | One-cycle pulse to invalidate one page |
| flush_va | output | 20 | Page number for flush_one |
| pt_base | output | 32 | Page-table base |
| cfg | output | 32 | Configuration word |

## Verification
The hardest case to reach is a fault arriving in the same cycle that software clears that same status bit. When that happens, the capture gate and the clear both act at one edge. The bench first leaves the page-fault bit pending with a known address. It then drives the clear write and a new page-fault event with a different address in one cycle, and expects the bit to remain set and the old address to remain in its register. A second hard case is a block request that is issued while the datapath is busy. The bench holds `dp_idle` low for several cycles and checks that the status bit stays 0. It then raises idle for exactly one cycle and checks that the blocked state sticks after idle falls again.

// File: rtl/mmurb_pkg.sv
package mmurb_pkg;

  localparam int unsigned NUM_FAULT = 4;
  localparam int unsigned DW        = 32;

  localparam int unsigned OFF_CTRL   = 'h000;
  localparam int unsigned OFF_CFG    = 'h004;
  localparam int unsigned OFF_STAT   = 'h008;
  localparam int unsigned OFF_FLALL  = 'h00C;
  localparam int unsigned OFF_FLONE  = 'h010;
  localparam int unsigned OFF_PTBASE = 'h014;
  localparam int unsigned OFF_INTST  = 'h018;
  localparam int unsigned OFF_INTCLR = 'h01C;
  localparam int unsigned OFF_FADDR0 = 'h024;
  localparam int unsigned OFF_VER    = 'h034;

  localparam logic [31:0] CODE_OFF = 32'h0;
  localparam logic [31:0] CODE_ON  = 32'h5;
  localparam logic [31:0] CODE_BLK = 32'h7;

  typedef enum logic [1:0] {
    MD_OFF = 2'd0,
    MD_ON  = 2'd1,
    MD_BLK = 2'd2
  } mode_e;

  function automatic logic [31:0] mode_code(mode_e m);
    case (m)
      MD_ON:   return CODE_ON;
      MD_BLK:  return CODE_BLK;
      default: return CODE_OFF;
    endcase
  endfunction

endpackage

// File: rtl/mmurb_ctrl.sv
module mmurb_ctrl
  import mmurb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_we,
  input  logic [31:0] ctrl_wdata,
  input  logic        fault_any,
  input  logic        int_pending,
  input  logic        dp_idle,
  output mode_e       mode_o,
  output logic        blocked_o
);

  mode_e mode_q, mode_n;
  logic  blk_q, blk_n;

  // next-state: faults override software writes; illegal codes ignored
  always_comb begin
    mode_n = mode_q;
    if (fault_any) begin
      mode_n = MD_BLK;
    end else if (ctrl_we) begin
      case (ctrl_wdata)
        CODE_OFF: mode_n = MD_OFF;
        CODE_ON:  mode_n = MD_ON;
        CODE_BLK: mode_n = MD_BLK;
        default:  mode_n = mode_q;
      endcase
    end
  end

  always_comb begin
    if (fault_any || int_pending) begin
      blk_n = 1'b1;
    end else if (mode_q == MD_BLK) begin
      blk_n = blk_q | dp_idle;
    end else begin
      blk_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_OFF;
      blk_q  <= 1'b0;
    end else begin
      mode_q <= mode_n;
      blk_q  <= blk_n;
    end
  end

  assign mode_o    = mode_q;
  assign blocked_o = blk_q;

  // R3: the blocked state is only entered after idle or a fault
  a_r3_block_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blk_q) |-> ($past(dp_idle) || $past(fault_any)));

  // R4: a fault blocks the unit at the next edge
  a_r4_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    fault_any |=> blk_q);

  // R8: pending interrupt keeps the unit blocked
  a_r8_pending_holds_block: assert property (@(posedge clk) disable iff (!rst_n)
    int_pending |-> blk_q);

endmodule

// File: rtl/mmurb_fault_log.sv
module mmurb_fault_log
  import mmurb_pkg::*;
#(
  parameter int unsigned NF = NUM_FAULT,
  parameter int unsigned AW = DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NF-1:0]    fault_evt,
  input  logic [NF*AW-1:0] fault_va,
  input  logic             clr_we,
  input  logic [NF-1:0]    clr_mask,
  output logic [NF-1:0]    int_q,
  output logic [NF*AW-1:0] addr_q
);

  logic [NF-1:0] int_n;
  logic [NF-1:0] cap_en;

  always_comb begin
    for (int i = 0; i < NF; i++) begin
      // a new event wins over a clear of the same bit
      int_n[i]  = fault_evt[i] | (int_q[i] & ~(clr_we & clr_mask[i]));
      cap_en[i] = fault_evt[i] & ~int_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) int_q <= '0;
    else        int_q <= int_n;
  end

  for (genvar g = 0; g < NF; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         addr_q[g*AW +: AW] <= '0;
      else if (cap_en[g]) addr_q[g*AW +: AW] <= fault_va[g*AW +: AW];
    end

    // R6: a pending slot keeps its first address
    a_r6_hold_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (int_q[g] && $past(int_q[g])) |-> $stable(addr_q[g*AW +: AW]));
  end

endmodule

// File: rtl/mmu_regblock.sv
module mmu_regblock
  import mmurb_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter logic [3:0]  VER_MAJOR  = 4'd2,
  parameter logic [6:0]  VER_MINOR  = 7'd5,
  parameter logic [31:0] CFG_WMASK  = 32'h00FF_FFFF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic                  dp_idle,
  input  logic [NUM_FAULT-1:0]  fault_evt,
  input  logic [NUM_FAULT*32-1:0] fault_va,
  output logic                  xlat_en,
  output logic                  blocked,
  output logic                  irq,
  output logic                  flush_all,
  output logic                  flush_one,
  output logic [31-PAGE_SHIFT:0] flush_va,
  output logic [31:0]           pt_base,
  output logic [31:0]           cfg
);

  localparam int unsigned NF  = NUM_FAULT;
  localparam int unsigned VAW = 32 - PAGE_SHIFT;
  localparam logic [10:0] VER_FIELD = {VER_MAJOR, VER_MINOR};

  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(OFF_CFG);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_FLALL  = ADDR_W'(OFF_FLALL);
  localparam logic [ADDR_W-1:0] A_FLONE  = ADDR_W'(OFF_FLONE);
  localparam logic [ADDR_W-1:0] A_PTBASE = ADDR_W'(OFF_PTBASE);
  localparam logic [ADDR_W-1:0] A_INTST  = ADDR_W'(OFF_INTST);
  localparam logic [ADDR_W-1:0] A_INTCLR = ADDR_W'(OFF_INTCLR);
  localparam logic [ADDR_W-1:0] A_VER    = ADDR_W'(OFF_VER);

  // write decode
  logic we_ctrl, we_cfg, we_flall, we_flone, we_ptb, we_clr;
  always_comb begin
    we_ctrl  = reg_wr && (reg_addr == A_CTRL);
    we_cfg   = reg_wr && (reg_addr == A_CFG);
    we_flall = reg_wr && (reg_addr == A_FLALL);
    we_flone = reg_wr && (reg_addr == A_FLONE);
    we_ptb   = reg_wr && (reg_addr == A_PTBASE);
    we_clr   = reg_wr && (reg_addr == A_INTCLR);
  end

  mode_e           mode;
  logic [NF-1:0]   int_st;
  logic [NF*32-1:0] faddr;

  mmurb_fault_log #(.NF(NF), .AW(32)) i_flog (
    .clk       (clk),
    .rst_n     (rst_n),
    .fault_evt (fault_evt),
    .fault_va  (fault_va),
    .clr_we    (we_clr),
    .clr_mask  (reg_wdata[NF-1:0]),
    .int_q     (int_st),
    .addr_q    (faddr)
  );

  mmurb_ctrl i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_we     (we_ctrl),
    .ctrl_wdata  (reg_wdata),
    .fault_any   (|fault_evt),
    .int_pending (|int_st),
    .dp_idle     (dp_idle),
    .mode_o      (mode),
    .blocked_o   (blocked)
  );

  // plain storage registers and flush pulses
  logic [31:0]    ptb_q, ptb_n, cfg_q, cfg_n;
  logic           fla_q, fla_n, flo_q, flo_n;
  logic [VAW-1:0] fva_q, fva_n;

  always_comb begin
    ptb_n = we_ptb ? reg_wdata : ptb_q;
    cfg_n = we_cfg ? (reg_wdata & CFG_WMASK) : cfg_q;
    fla_n = we_flall & reg_wdata[0];
    flo_n = we_flone & reg_wdata[0];
    fva_n = flo_n ? reg_wdata[31:PAGE_SHIFT] : fva_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptb_q <= '0;
      cfg_q <= '0;
      fla_q <= 1'b0;
      flo_q <= 1'b0;
      fva_q <= '0;
    end else begin
      ptb_q <= ptb_n;
      cfg_q <= cfg_n;
      fla_q <= fla_n;
      flo_q <= flo_n;
      fva_q <= fva_n;
    end
  end

  // read mux
  always_comb begin
    case (reg_addr)
      A_CTRL:   reg_rdata = mode_code(mode);
      A_CFG:    reg_rdata = cfg_q;
      A_STAT:   reg_rdata = {31'b0, blocked};
      A_PTBASE: reg_rdata = ptb_q;
      A_INTST:  reg_rdata = 32'(int_st);
      A_VER:    reg_rdata = {VER_FIELD, 21'b0};
      default:  reg_rdata = '0;
    endcase
    for (int i = 0; i < NF; i++) begin
      if (reg_addr == ADDR_W'(OFF_FADDR0 + 4 * i)) reg_rdata = faddr[i*32 +: 32];
    end
  end

  assign xlat_en   = (mode == MD_ON) && !blocked;
  assign irq       = |int_st;
  assign flush_all = fla_q;
  assign flush_one = flo_q;
  assign flush_va  = fva_q;
  assign pt_base   = ptb_q;
  assign cfg       = cfg_q;

  // R9: each flush pulse follows a qualifying write
  a_r9_flush_all_cause: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |-> $past(reg_wr && (reg_addr == A_FLALL) && reg_wdata[0]));

  a_r9_flush_one_cause: assert property (@(posedge clk) disable iff (!rst_n)
    flush_one |-> $past(reg_wr && (reg_addr == A_FLONE) && reg_wdata[0]));

endmodule

// File: tb/test_mmu_regblock.sv
module test_mmu_regblock;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         reg_wr;
  logic [7:0]   reg_addr;
  logic [31:0]  reg_wdata;
  logic [31:0]  reg_rdata;
  logic         dp_idle;
  logic [3:0]   fault_evt;
  logic [127:0] fault_va;
  logic         xlat_en, blocked, irq, flush_all, flush_one;
  logic [19:0]  flush_va;
  logic [31:0]  pt_base, cfg;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;  // 250 MHz

  mmu_regblock i_mmu_regblock (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dp_idle(dp_idle),
    .fault_evt(fault_evt), .fault_va(fault_va), .xlat_en(xlat_en),
    .blocked(blocked), .irq(irq), .flush_all(flush_all), .flush_one(flush_one),
    .flush_va(flush_va), .pt_base(pt_base), .cfg(cfg)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic rchk(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fault(logic [3:0] evt, logic [127:0] va);
    @(negedge clk);
    fault_evt = evt; fault_va = va;
    @(negedge clk);
    fault_evt = '0;
  endtask

  task automatic t_reset;
    rchk("R1 ctrl", 8'h00, 32'h0);
    rchk("R1 cfg", 8'h04, 32'h0);
    rchk("R1 status", 8'h08, 32'h0);
    rchk("R1 intst", 8'h18, 32'h0);
    rchk("R1 ptbase", 8'h14, 32'h0);
    for (int i = 0; i < 4; i++) rchk("R1 faddr", 8'(8'h24 + 4 * i), 32'h0);
    rchk("R1 version", 8'h34, (32'd2 << 28) | (32'd5 << 21));
    chk("R1 outs", {29'b0, xlat_en, blocked, irq}, 32'h0);
  endtask

  task automatic t_enable;
    wr(8'h00, 32'h5); cycles(1);
    chk("R2 xlat on", 32'(xlat_en), 32'h1);
    rchk("R2 ctrl 5", 8'h00, 32'h5);
    wr(8'h00, 32'h3); cycles(1);
    rchk("R2 illegal ignored", 8'h00, 32'h5);
    chk("R2 xlat kept", 32'(xlat_en), 32'h1);
    wr(8'h00, 32'h0); cycles(1);
    chk("R2 xlat off", 32'(xlat_en), 32'h0);
    rchk("R2 ctrl 0", 8'h00, 32'h0);
    wr(8'h00, 32'h5); cycles(1);
  endtask

  task automatic t_block;
    dp_idle = 1'b0;
    wr(8'h00, 32'h7);
    chk("R3 xlat drops", 32'(xlat_en), 32'h0);
    cycles(4);
    rchk("R3 not blocked while busy", 8'h08, 32'h0);
    @(negedge clk); dp_idle = 1'b1;
    @(negedge clk); dp_idle = 1'b0;
    rchk("R3 blocked after idle", 8'h08, 32'h1);
    cycles(3);
    chk("R3 blocked sticks", 32'(blocked), 32'h1);
    wr(8'h00, 32'h5); cycles(1);
    chk("R3 unblocked", 32'(blocked), 32'h0);
    chk("R3 xlat back", 32'(xlat_en), 32'h1);
  endtask

  task automatic t_fault_single;
    logic [127:0] va;
    va = '0; va[63:32] = 32'h1234_5000;
    fault(4'b0010, va);
    rchk("R4 intst", 8'h18, 32'h2);
    chk("R4 irq", 32'(irq), 32'h1);
    chk("R4 blocked", 32'(blocked), 32'h1);
    rchk("R4 wr-chan addr", 8'h28, 32'h1234_5000);
    rchk("R4 page addr untouched", 8'h24, 32'h0);
    rchk("R4 ctrl forced", 8'h00, 32'h7);
    va[63:32] = 32'hDEAD_0000;
    fault(4'b0010, va);
    rchk("R6 first addr kept", 8'h28, 32'h1234_5000);
    // R8: re-enable with bit still pending
    wr(8'h00, 32'h5); cycles(2);
    chk("R8 held blocked", 32'(blocked), 32'h1);
    chk("R8 xlat held off", 32'(xlat_en), 32'h0);
    wr(8'h1C, 32'h1);
    rchk("R5 other bit no effect", 8'h18, 32'h2);
    wr(8'h1C, 32'h2);
    rchk("R5 cleared", 8'h18, 32'h0);
    cycles(1);
    chk("R8 resume blocked", 32'(blocked), 32'h0);
    chk("R8 resume xlat", 32'(xlat_en), 32'h1);
    chk("R8 irq low", 32'(irq), 32'h0);
  endtask

  task automatic t_fault_multi;
    logic [127:0] va;
    va = {32'hD000_3000, 32'hC000_2000, 32'hB000_1000, 32'hA000_0000};
    fault(4'b1101, va);
    rchk("R7 intst", 8'h18, 32'hD);
    rchk("R7 page", 8'h24, 32'hA000_0000);
    rchk("R7 wr-chan untouched", 8'h28, 32'h1234_5000);
    rchk("R7 rd-chan", 8'h2C, 32'hC000_2000);
    rchk("R7 dflt", 8'h30, 32'hD000_3000);
    // clear all three while a new page fault arrives in the same cycle
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h1C; reg_wdata = 32'hD;
    fault_evt = 4'b0001; fault_va = {96'b0, 32'h5555_5000};
    @(negedge clk);
    reg_wr = 1'b0; fault_evt = '0;
    rchk("R5 set wins over clear", 8'h18, 32'h1);
    rchk("R6 no capture while pending", 8'h24, 32'hA000_0000);
    wr(8'h1C, 32'h1);
    rchk("R5 all clear", 8'h18, 32'h0);
    wr(8'h00, 32'h5); cycles(1);
    chk("R8 running again", 32'(xlat_en), 32'h1);
  endtask

  task automatic t_flush;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h0C; reg_wdata = 32'h1;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R9 flush_all pulse", 32'(flush_all), 32'h1);
    @(negedge clk);
    chk("R9 flush_all one cycle", 32'(flush_all), 32'h0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h10; reg_wdata = 32'hABCD_E001;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R9 flush_one pulse", 32'(flush_one), 32'h1);
    chk("R9 flush_va", 32'(flush_va), 32'h000A_BCDE);
    @(negedge clk);
    chk("R9 flush_one one cycle", 32'(flush_one), 32'h0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h0C; reg_wdata = 32'h0;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R9 bit0 clear no pulse", 32'(flush_all), 32'h0);
    rchk("R9 flush reads 0", 8'h10, 32'h0);
  endtask

  task automatic t_regs;
    wr(8'h14, 32'h8765_4000);
    rchk("R10 ptbase", 8'h14, 32'h8765_4000);
    chk("R10 pt_base port", pt_base, 32'h8765_4000);
    wr(8'h04, 32'hFFFF_FFFF);
    rchk("R10 cfg masked", 8'h04, 32'h00FF_FFFF);
    chk("R10 cfg port", cfg, 32'h00FF_FFFF);
  endtask

  task automatic t_unmapped;
    rchk("R11 0x020", 8'h20, 32'h0);
    rchk("R11 0x038", 8'h38, 32'h0);
    rchk("R11 unaligned", 8'h15, 32'h0);
    wr(8'h18, 32'hF);
    rchk("R11 intst write ignored", 8'h18, 32'h0);
    chk("R11 irq low", 32'(irq), 32'h0);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    dp_idle = 1'b0; fault_evt = '0; fault_va = '0;
    cycles(4);
    rst_n = 1'b1;
    cycles(1);
    t_reset();
    t_enable();
    t_block();
    t_fault_single();
    t_fault_multi();
    t_flush();
    t_regs();
    t_unmapped();
    done = 1;
    finish_run();
  end

endmodule